// File: doc/BRIEF.md
# DMA Beat Address Generator

This block produces the source and destination byte addresses for every beat of a DMA block transfer. Its configuration is captured in a single load cycle: two ending addresses, an initial beat count, a beat-size code, an increment enable for each side, a step-select bit and a step-size code. Each side then either holds its address or walks forward. The stored addresses are where the block ends, so the address of the current beat is computed backward from the number of beats still remaining.

A bus master or channel engine reads `src_addr_o` and `dst_addr_o` and pulses `beat_done_i` after it finishes each beat. The remaining-beat counter then decrements. When the counter reaches zero, `done_o` pulses for one cycle. Only one of the two sides gets the programmable power-of-two stride, and the step-select bit picks which one. An incrementing side that does not get the stride advances by one beat size.

Top module: `dma_beat_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `beats_left_o` is 0, and `active_o` and `done_o` are 0.
- R2: A `load_i` cycle captures all configuration inputs. From the next cycle on, `beats_left_o` equals the loaded count and `active_o` is 1 exactly when that count is nonzero.
- R3: A side whose captured increment enable is 0 outputs its captured ending address unchanged for every beat of the block.
- R4: An incrementing side outputs its ending address minus `beats_left_o` times that side's increment in bytes. Its address therefore rises by exactly one increment on each accepted beat.
- R5: Beat-size codes 0, 1 and 2 give beats of 1, 2 and 4 bytes. The reserved code 3 is treated as 4 bytes.
- R6: With step-select 1, the source increment is the beat size times 2 to the power of the 3-bit step-size code (1 to 128 beats), and the destination increment is one beat size.
- R7: With step-select 0, the destination increment is the beat size times 2 to the power of the step-size code, and the source increment is one beat size.
- R8: A `beat_done_i` pulse while `beats_left_o` is nonzero lowers the count by one. After the last beat, both addresses equal their ending addresses.
- R9: `done_o` is high for exactly one cycle: the cycle after the strobe that takes the count from 1 to 0.
- R10: A `beat_done_i` pulse while the count is 0 has no effect. The count stays 0, no `done_o` pulse appears, and the addresses do not change.
- R11: Loading a count of 0 leaves `active_o` low and raises `done_o` for one cycle on the next cycle, with no beats issued.
- R12: When `load_i` and `beat_done_i` are high in the same cycle, the load wins. The new count and configuration apply without any decrement.
- R13: Address arithmetic wraps modulo 2^32, so an ending address below the total span yields start addresses near the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture configuration and start a new block |
| src_end_i | input | 32 | Source ending address |
| dst_end_i | input | 32 | Destination ending address |
| beat_cnt_i | input | 16 | Initial number of beats |
| beat_size_i | input | 2 | Beat size code: 0=1 B, 1=2 B, 2=4 B, 3=4 B |
| src_inc_i | input | 1 | Source increments when 1 |
| dst_inc_i | input | 1 | Destination increments when 1 |
| step_sel_i | input | 1 | 1: source gets programmable stride; 0: destination does |
| step_size_i | input | 3 | Stride exponent, in beats as 2^code |
| beat_done_i | input | 1 | One beat has completed |
| src_addr_o | output | 32 | Source address of current beat |
| dst_addr_o | output | 32 | Destination address of current beat |
| beats_left_o | output | 16 | Remaining beat count |
| active_o | output | 1 | Beats remain in the current block |
| done_o | output | 1 | One-cycle block completion pulse |

## Verification
The assertions take for granted that configuration inputs matter only in a load cycle. They also assume that every input is a known value at each rising edge, and that an accepted beat never coincides with a load. The design itself enforces the last point through load priority. The stimulus changes configuration only together with `load_i` and drives every input just after the falling edge. It keeps the loaded counts small, so each block can be stepped through beat by beat against a model computed from the ending address, the remaining count and the per-side shift.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [1:0] {
    BEAT_1B  = 2'd0,
    BEAT_2B  = 2'd1,
    BEAT_4B  = 2'd2,
    BEAT_RSV = 2'd3
  } beat_size_e;
endpackage

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] left_o,
  output logic             advance_o,
  output logic             done_o
);
  logic [CNT_W-1:0] left_q;
  logic             done_q;

  // load has priority; strobes on an empty counter are dropped
  assign advance_o = beat_i && !load_i && (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      left_q <= cnt_i;
      done_q <= (cnt_i == '0);
    end else if (advance_o) begin
      left_q <= left_q - 1'b1;
      done_q <= (left_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign left_o = left_q;
  assign done_o = done_q;

  p_load_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> left_o == $past(cnt_i));

  p_dec_by_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !load_i && left_o != '0) |=> left_o == $past(left_o) - 1'b1);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && left_o == '0) |=> (left_o == '0 && !done_o));

  p_done_at_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> left_o == '0);

  p_zero_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && cnt_i == '0) |=> done_o);
endmodule

// File: rtl/addr_side.sv
module addr_side
  import dma_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              inc_i,
  input  logic              use_step_i,
  input  logic [1:0]        beat_size_i,
  input  logic [STEP_W-1:0] step_size_i,
  input  logic [CNT_W-1:0]  beats_left_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SHIFT_W = $clog2((2 ** STEP_W) + 2);

  logic [ADDR_W-1:0]  end_q;
  logic               inc_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [SHIFT_W-1:0] base_sh, shift_d;
  logic [ADDR_W-1:0]  offset;

  // increment is a power of two: log2(bytes) plus optional stride exponent
  always_comb begin
    base_sh = (beat_size_i == BEAT_RSV) ? SHIFT_W'(2) : SHIFT_W'(beat_size_i);
    shift_d = use_step_i ? base_sh + SHIFT_W'(step_size_i) : base_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q   <= '0;
      inc_q   <= 1'b0;
      shift_q <= '0;
    end else if (load_i) begin
      end_q   <= end_i;
      inc_q   <= inc_i;
      shift_q <= shift_d;
    end
  end

  assign offset = ADDR_W'(beats_left_i) << shift_q;
  assign addr_o = inc_q ? end_q - offset : end_q;

  p_stride_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && inc_q) |=>
      addr_o == $past(addr_o) + (ADDR_W'(1) << $past(shift_q)));

  p_static_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !inc_q) |=> $stable(addr_o));

  p_load_static_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !inc_i) |=> addr_o == $past(end_i));
endmodule

// File: rtl/dma_beat_addr_gen.sv
module dma_beat_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned C_W = CNT_W,
  parameter int unsigned S_W = STEP_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] src_end_i,
  input  logic [A_W-1:0] dst_end_i,
  input  logic [C_W-1:0] beat_cnt_i,
  input  logic [1:0]     beat_size_i,
  input  logic           src_inc_i,
  input  logic           dst_inc_i,
  input  logic           step_sel_i,
  input  logic [S_W-1:0] step_size_i,
  input  logic           beat_done_i,
  output logic [A_W-1:0] src_addr_o,
  output logic [A_W-1:0] dst_addr_o,
  output logic [C_W-1:0] beats_left_o,
  output logic           active_o,
  output logic           done_o
);
  localparam int unsigned NSIDE = 2; // 0: source, 1: destination

  logic [C_W-1:0] left;
  logic           advance;
  logic [A_W-1:0] end_a  [NSIDE];
  logic [A_W-1:0] addr_a [NSIDE];
  logic           inc_a  [NSIDE];
  logic           step_a [NSIDE];

  assign end_a[0]  = src_end_i;
  assign end_a[1]  = dst_end_i;
  assign inc_a[0]  = src_inc_i;
  assign inc_a[1]  = dst_inc_i;
  assign step_a[0] = step_sel_i;
  assign step_a[1] = !step_sel_i;

  beat_counter #(.CNT_W(C_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .cnt_i     (beat_cnt_i),
    .beat_i    (beat_done_i),
    .left_o    (left),
    .advance_o (advance),
    .done_o    (done_o)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    addr_side #(.ADDR_W(A_W), .CNT_W(C_W), .STEP_W(S_W)) u_side (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load_i),
      .end_i        (end_a[s]),
      .inc_i        (inc_a[s]),
      .use_step_i   (step_a[s]),
      .beat_size_i  (beat_size_i),
      .step_size_i  (step_size_i),
      .beats_left_i (left),
      .advance_i    (advance),
      .addr_o       (addr_a[s])
    );
  end

  assign src_addr_o   = addr_a[0];
  assign dst_addr_o   = addr_a[1];
  assign beats_left_o = left;
  assign active_o     = (left != '0);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> !done_o);

  p_done_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !active_o);
endmodule

// File: tb/dma_beat_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_beat_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, beat = 1'b0;
  logic [31:0] src_end = '0, dst_end = '0;
  logic [15:0] cnt = '0;
  logic [1:0]  bsz = '0;
  logic        sinc = 1'b0, dinc = 1'b0, ssel = 1'b0;
  logic [2:0]  step = '0;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] left;
  logic        active, done;

  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_beat_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .src_end_i(src_end), .dst_end_i(dst_end), .beat_cnt_i(cnt),
    .beat_size_i(bsz), .src_inc_i(sinc), .dst_inc_i(dinc),
    .step_sel_i(ssel), .step_size_i(step), .beat_done_i(beat),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr),
    .beats_left_o(left), .active_o(active), .done_o(done)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] e, logic inc, int sh, int l);
    return inc ? e - (32'(l) << sh) : e;
  endfunction

  function automatic int base_shift(logic [1:0] b);
    return (b == 2'd3) ? 2 : int'(b);
  endfunction

  task automatic do_load(logic [31:0] se, logic [31:0] de, logic [15:0] c,
                         logic [1:0] b, logic si, logic di, logic sl, logic [2:0] st,
                         logic with_beat);
    src_end = se; dst_end = de; cnt = c; bsz = b;
    sinc = si; dinc = di; ssel = sl; step = st;
    load = 1'b1; beat = with_beat;
    @(negedge clk);
    load = 1'b0; beat = 1'b0;
  endtask

  task automatic do_beat();
    beat = 1'b1;
    @(negedge clk);
    beat = 1'b0;
  endtask

  // steps through the rest of the loaded block, checking every beat
  task automatic walk(string tag, int from);
    int ssh = base_shift(bsz) + (ssel ? int'(step) : 0);
    int dsh = base_shift(bsz) + (ssel ? 0 : int'(step));
    for (int l = from; l >= 1; l--) begin
      chk({tag, " left"}, 32'(left), 32'(l));
      chk({tag, " active R2"}, 32'(active), 32'd1);
      chk({tag, " src"}, src_addr, model(src_end, sinc, ssh, l));
      chk({tag, " dst"}, dst_addr, model(dst_end, dinc, dsh, l));
      do_beat();
      chk({tag, " done R9"}, 32'(done), (l == 1) ? 32'd1 : 32'd0);
    end
    chk({tag, " end src R8"}, src_addr, src_end);
    chk({tag, " end dst R8"}, dst_addr, dst_end);
    chk({tag, " left R8"}, 32'(left), 32'd0);
    @(negedge clk);
    chk({tag, " done drop R9"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 left in reset", 32'(left), 32'd0);
    chk("R1 active in reset", 32'(active), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 left after reset", 32'(left), 32'd0);
    chk("R1 done after reset", 32'(done), 32'd0);
  endtask

  task automatic t_src_step();   // R6: source gets 2-beat stride, 2-byte beats
    do_load(32'h1010, 32'h2008, 16'd4, 2'd1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0);
    chk("R6 first src", src_addr, 32'h1000);
    chk("R6 first dst", dst_addr, 32'h2000);
    walk("R6/R4", 4);
  endtask

  task automatic t_dst_step();   // R7: destination gets 8-beat stride, 4-byte beats
    do_load(32'h0000_3010, 32'h0000_8060, 16'd3, 2'd2, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0);
    chk("R7 first src", src_addr, 32'h0000_3004);
    chk("R7 first dst", dst_addr, 32'h0000_8000);
    walk("R7/R4", 3);
  endtask

  task automatic t_static();     // R3
    do_load(32'hA000_0000, 32'hB000_0004, 16'd3, 2'd0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk("R3 src static", src_addr, 32'hA000_0000);
      chk("R3 dst static", dst_addr, 32'hB000_0004);
      do_beat();
    end
    chk("R3 done", 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_sizes();      // R5: byte beats and reserved code
    do_load(32'h100, 32'h200, 16'd5, 2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    chk("R5 1-byte src", src_addr, 32'hFB);
    walk("R5 size0", 5);
    do_load(32'h100, 32'h200, 16'd2, 2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    chk("R5 code3 as 4 bytes", src_addr, 32'hF8);
    walk("R5 size3", 2);
  endtask

  task automatic t_max_step();   // R6 at largest code: 128-beat stride
    do_load(32'h0001_0000, 32'h40, 16'd3, 2'd2, 1'b1, 1'b1, 1'b1, 3'd7, 1'b0);
    chk("R6 max src", src_addr, 32'h0001_0000 - 32'd1536);
    chk("R6 max dst", dst_addr, 32'h34);
    walk("R6 max", 3);
  endtask

  task automatic t_ignore();     // R10
    logic [31:0] s0 = src_addr, d0 = dst_addr;
    do_beat();
    chk("R10 left stays 0", 32'(left), 32'd0);
    chk("R10 no done", 32'(done), 32'd0);
    chk("R10 src unchanged", src_addr, s0);
    do_beat();
    chk("R10 dst unchanged", dst_addr, d0);
    chk("R10 active low", 32'(active), 32'd0);
  endtask

  task automatic t_zero();       // R11
    do_load(32'h500, 32'h600, 16'd0, 2'd2, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0);
    chk("R11 done pulse", 32'(done), 32'd1);
    chk("R11 inactive", 32'(active), 32'd0);
    chk("R11 src at end", src_addr, 32'h500);
    @(negedge clk);
    chk("R11 done drop", 32'(done), 32'd0);
  endtask

  task automatic t_priority();   // R12
    do_load(32'h1000, 32'h2000, 16'd5, 2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    do_beat();
    do_beat();
    chk("R12 pre left", 32'(left), 32'd3);
    do_load(32'h4000, 32'h5000, 16'd2, 2'd1, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1);
    chk("R12 load wins", 32'(left), 32'd2);
    chk("R12 no done", 32'(done), 32'd0);
    chk("R12 new src", src_addr, 32'h4000 - 32'd16);
    walk("R12", 2);
  endtask

  task automatic t_wrap();       // R13
    do_load(32'h10, 32'h8, 16'd8, 2'd2, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0);
    chk("R13 src wraps", src_addr, 32'hFFFF_FFF0);
    chk("R13 dst wraps", dst_addr, 32'hFFFF_FFE8);
    walk("R13", 8);
  endtask

  initial begin
    #(200000 * 5);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_src_step();
    t_dst_step();
    t_static();
    t_sizes();
    t_max_step();
    t_ignore();
    t_zero();
    t_priority();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule